// File: doc/BRIEF.md
# Peripheral Reference Clock Generator

This block derives two peripheral reference clock enables from a shared control word. Three upstream sources, called PLL A, PLL B and PLL C, are modelled as strobe generators. Each one is driven by a common reference strobe and qualified by its own configuration word. The control word selects one source, divides its strobes by a programmable 6-bit ratio, and gates the result separately onto two outputs.

Everything runs in one system clock domain, and every "clock" is a one-cycle enable strobe. A host writes the four configuration words through a simple write port. The downstream peripherals use `tick_out0` and `tick_out1` as clock enables.

Top module: `periph_refclk_gen`

## Requirements
- R1: The divide ratio D is control bits [13:8]. A value of 0 acts as D=1. The block emits one output pulse for every D strobes of the selected source, so the output count is the source strobe count divided by D, rounded down.
- R2: Control bits [5:4] select the source. Codes 0 and 1 both select PLL A, code 2 selects PLL B and code 3 selects PLL C.
- R3: Control bit 0 enables `tick_out0` and control bit 1 enables `tick_out1`. An output whose enable bit is clear never pulses.
- R4: When bit 4 of a PLL word is set, that source repeats every reference strobe unchanged in the same cycle, even if bits 0 or 1 are set.
- R5: When bit 4 of a PLL word is clear and bit 0 or bit 1 is set, that source produces no strobes.
- R6: When a PLL runs (bits 4, 1 and 0 all clear), each reference strobe starts a burst of M source strobes on consecutive cycles, starting one cycle later. M is PLL bits [18:12], and 0 means M=128. Bit 3 and the other bits have no effect.
- R7: `cfg_sel` addresses the word that a write with `cfg_we` high updates: 0 is the control word, 1 is PLL A, 2 is PLL B and 3 is PLL C. Reset loads the control word with 0x00003F03 (D=63, PLL A, both outputs on) and each PLL word with 0x0001A008 (running, M=26).
- R8: While `rst_n` is low, both outputs stay low whatever `ref_tick` does. Pulses resume after `rst_n` rises.
- R9: A write to the control word restarts the divide count from zero. A source strobe in the same cycle as that write is discarded.
- R10: An output pulse is high for exactly the one cycle after the source strobe that completes a count of D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Raw reference strobe, one cycle wide |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Word select: 0 control, 1 PLL A, 2 PLL B, 3 PLL C |
| cfg_wdata | input | 32 | Configuration write data |
| tick_out0 | output | 1 | Reference enable for peripheral 0 |
| tick_out1 | output | 1 | Reference enable for peripheral 1 |

## Verification
A control-word write and a selected-source strobe can land in the same cycle. In that case the write's restart of the divide count competes with the strobe's advance of it. The bench provokes this with a bypassed source and D=2. One reference strobe first leaves the count at one. A rewrite of the control word is then issued together with a second reference strobe. The collision is judged correct only if no pulse results from it, no pulse follows the next strobe, and exactly one pulse follows the strobe after that.

// File: rtl/periph_refclk_gen.sv
module periph_refclk_gen #(
  parameter int          DIV_W    = 6,
  parameter int          MUL_W    = 7,
  parameter logic [31:0] CTRL_RST = 32'h0000_3F03,
  parameter logic [31:0] PLL_RST  = 32'h0001_A008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        tick_out0,
  output logic        tick_out1
);

  localparam int DIV_LSB = 8;
  localparam int SEL_LSB = 4;
  localparam int MUL_LSB = 12;
  localparam int BYP_BIT = 4;
  localparam int RST_BIT = 0;
  localparam int PD_BIT  = 1;
  localparam int NPLL    = 3;
  localparam int CW      = MUL_W + 1;
  localparam int MUL_MAX = 1 << MUL_W;

  logic [31:0]      ctrl_q;
  logic [NPLL-1:0]  pll_tick;
  logic             src_tick;
  logic [DIV_W-1:0] div_f, div_eff, div_cnt;
  logic             div_last, hit, ctrl_wr;
  logic             p0_q, p1_q;

  assign ctrl_wr = cfg_we && (cfg_sel == 2'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= cfg_wdata;

  for (genvar g = 0; g < NPLL; g++) begin : g_pll
    logic [31:0]      word_q;
    logic [CW-1:0]    burst_q;
    logic [MUL_W-1:0] mul_f;
    logic [CW-1:0]    mul_eff;
    logic             byp, stop;

    assign byp     = word_q[BYP_BIT];
    assign stop    = word_q[RST_BIT] | word_q[PD_BIT];
    assign mul_f   = word_q[MUL_LSB +: MUL_W];
    assign mul_eff = (mul_f == '0) ? CW'(MUL_MAX) : {1'b0, mul_f};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        word_q  <= PLL_RST;
        burst_q <= '0;
      end else begin
        if (cfg_we && cfg_sel == 2'(g + 1)) word_q <= cfg_wdata;
        if (byp || stop)          burst_q <= '0;
        else if (ref_tick)        burst_q <= mul_eff;
        else if (burst_q != '0)   burst_q <= burst_q - 1'b1;
      end

    assign pll_tick[g] = byp ? ref_tick : (!stop && burst_q != '0);

    AST_STOPPED_PLL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp && stop) |=> (burst_q == '0)); // R5
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      burst_q <= CW'(MUL_MAX)); // R6
  end

  always_comb
    case (ctrl_q[SEL_LSB +: 2])
      2'd0, 2'd1: src_tick = pll_tick[0];
      2'd2:       src_tick = pll_tick[1];
      default:    src_tick = pll_tick[2];
    endcase

  assign div_f    = ctrl_q[DIV_LSB +: DIV_W];
  assign div_eff  = (div_f == '0) ? DIV_W'(1) : div_f;
  assign div_last = (div_cnt == div_eff - 1'b1);
  assign hit      = src_tick && div_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      p0_q    <= 1'b0;
      p1_q    <= 1'b0;
    end else if (ctrl_wr) begin
      div_cnt <= '0;
      p0_q    <= 1'b0;
      p1_q    <= 1'b0;
    end else begin
      if (src_tick) div_cnt <= div_last ? '0 : div_cnt + 1'b1;
      p0_q <= hit && ctrl_q[0];
      p1_q <= hit && ctrl_q[1];
    end

  assign tick_out0 = p0_q;
  assign tick_out1 = p1_q;

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < div_eff); // R1
  AST_OUT0_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out0 |-> $past(ctrl_q[0])); // R3
  AST_OUT1_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out1 |-> $past(ctrl_q[1])); // R3
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (div_cnt == '0 && !tick_out0 && !tick_out1)); // R9
  AST_PULSE_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_out0 || tick_out1) |-> $past(src_tick)); // R10

endmodule

// File: tb/sim_periph_refclk_gen.sv
module sim_periph_refclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        tick_out0, tick_out1;

  int checks = 0, fails = 0, c0 = 0, c1 = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  periph_refclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tick_out0(tick_out0), .tick_out1(tick_out1));

  localparam int NV = 8;
  localparam logic [31:0] V_A    [NV] = '{32'h10, 32'h10, 32'h3000, 32'h10, 32'h10, 32'h10, 32'h10, 32'h13};
  localparam logic [31:0] V_B    [NV] = '{32'h13, 32'h13, 32'h13, 32'h5000, 32'h13, 32'h5001, 32'h13, 32'h13};
  localparam logic [31:0] V_C    [NV] = '{32'h13, 32'h13, 32'h13, 32'h13, 32'h0, 32'h13, 32'h2002, 32'h13};
  localparam logic [31:0] V_CTRL [NV] = '{32'h103, 32'h011, 32'h202, 32'h323, 32'h3F33, 32'h123, 32'h133, 32'h103};
  localparam int          V_N    [NV] = '{5, 4, 4, 3, 2, 3, 3, 3};
  localparam int          V_E0   [NV] = '{5, 4, 0, 5, 4, 0, 0, 3};
  localparam int          V_E1   [NV] = '{5, 0, 6, 5, 4, 0, 0, 3};

  function automatic string vreq(int i);
    case (i)
      0: return "R4 R1 R2 bypass divide-by-1";
      1: return "R1 R2 R3 code1 zero-divisor out0-only";
      2: return "R6 R3 multiply out1-only";
      3: return "R2 R6 R1 PLL B source";
      4: return "R6 R1 PLL C zero-multiplier";
      5: return "R5 reset bit stops source";
      6: return "R5 power-down bit stops source";
      default: return "R4 bypass overrides reset bit";
    endcase
  endfunction

  task automatic one_cycle();
    @(negedge clk);
    c0 += int'(tick_out0);
    c1 += int'(tick_out1);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    one_cycle();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ref();
    ref_tick = 1'b1;
    one_cycle();
    ref_tick = 1'b0;
    repeat (140) one_cycle();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) one_cycle();
    // R8: reference strobes during reset give no pulses
    c0 = 0; c1 = 0;
    for (int k = 0; k < 3; k++) pulse_ref();
    chk("R8 out0 during reset", c0, 0);
    chk("R8 out1 during reset", c1, 0);
    rst_n = 1'b1;
    one_cycle();
    chk("R7 reset state out0", int'(tick_out0), 0);
    // R7: reset words give M=26, D=63: 3 strobes -> 78 source -> 1 pulse
    c0 = 0; c1 = 0;
    for (int k = 0; k < 3; k++) pulse_ref();
    chk("R7 R8 reset-value out0", c0, 1);
    chk("R7 R8 reset-value out1", c1, 1);

    for (int i = 0; i < NV; i++) begin
      wr(2'd1, V_A[i]); wr(2'd2, V_B[i]); wr(2'd3, V_C[i]); wr(2'd0, V_CTRL[i]);
      c0 = 0; c1 = 0;
      for (int k = 0; k < V_N[i]; k++) pulse_ref();
      chk({vreq(i), " out0"}, c0, V_E0[i]);
      chk({vreq(i), " out1"}, c1, V_E1[i]);
    end

    // R9 collision: control write in same cycle as source strobe
    wr(2'd1, 32'h10); wr(2'd0, 32'h203);
    c0 = 0; c1 = 0;
    pulse_ref();
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h203; ref_tick = 1'b1;
    one_cycle();
    cfg_we = 1'b0; ref_tick = 1'b0;
    repeat (140) one_cycle();
    pulse_ref();
    chk("R9 no pulse after collision", c0, 0);
    pulse_ref();
    chk("R9 pulse after restart count", c0, 1);
    chk("R10 single-cycle pulse out1", c1, 1);

    // R8: mid-run reset holds outputs then restores reset words
    wr(2'd0, 32'h103);
    rst_n = 1'b0;
    c0 = 0; c1 = 0;
    pulse_ref();
    chk("R8 out0 held in mid-run reset", c0, 0);
    rst_n = 1'b1;
    one_cycle();
    c0 = 0; c1 = 0;
    for (int k = 0; k < 3; k++) pulse_ref();
    chk("R8 R7 resume after reset", c0, 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule